// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic datapath of a small accumulator-style processor core. For each operation it takes the working register, a file-register operand and an 8-bit literal. It also takes a 5-bit operation code, a destination bit and the current carry, digit-carry and zero flags. It produces one result byte and a write enable for either the working register or the file register. It also produces the three flags and a mask that marks which flags the operation changed.

The covered operations are:

- add, subtract, and their carry/borrow-chained forms;
- add and subtract with a literal;
- AND, OR and XOR with either source;
- complement, increment and decrement;
- arithmetic and logical shifts, and rotates through carry;
- nibble swap, the moves, and clears.

A flag that an operation does not affect passes through with the value the core supplied. The core can then write all three status bits back on every operation.

The block registers its outputs. Each accepted operation produces one output beat on the next clock. Instruction fetch, register-file storage and bank selection belong to the surrounding core.

Top module: `byte_alu`

## Requirements
- R1: An operation presented with `inValid` high produces `outValid` high, with its result, enables and flags, on the next rising clock edge. A cycle without `inValid` produces `outValid` low and both write enables low on the next edge. Reset clears `outValid`, `result`, both enables, all flags and `flagMask`.
- R2: At most one write enable is set per beat. For operations that follow `dBit`, `dBit`=0 writes the working register and `dBit`=1 writes the file register. Literal operations and clear-W always write the working register. Store and clear-F always write the file register. Undefined codes 26 to 31 write nothing, report a zero result and change no flag.
- R3: Add (code 0) computes f+W. Add-with-carry (code 1) computes f+W+C. Add-literal (code 4) computes k+W. Each sets C to the carry out of bit 7, DC to the carry out of bit 3 and Z to (result==0).
- R4: Subtract (code 2) computes f−W. Subtract-literal (code 5) computes k−W. Subtract-with-borrow (code 3) computes f−W−(1−C). C=1 means no borrow out of bit 7 and DC=1 means no borrow out of bit 3. Z is updated as well.
- R5: AND, OR and XOR with f (codes 6, 7, 8) or with k (codes 9, 10, 11) combine the operand with W. Complement (12), increment (13), decrement (14) and pass-f (15) act on f. All of these update only Z.
- R6: Clear-F (17) and clear-W (18) produce 0, set Z, and leave C and DC unchanged.
- R7: Arithmetic right shift (19) keeps bit 7 and moves bit 0 into C. Logical left shift (20) shifts in a 0 at bit 0 and moves bit 7 into C. Logical right shift (21) shifts in a 0 at bit 7 and moves bit 0 into C. Each of the three updates C and Z.
- R8: Rotate left (22) shifts the incoming C into bit 0 and moves bit 7 into C. Rotate right (23) shifts C into bit 7 and moves bit 0 into C. Both update only C.
- R9: Swap (24) exchanges the nibbles of f. Store (16) writes W to the file register. Load-literal (25) writes k to W. None of these three changes a flag.
- R10: A flag not updated by the operation is output equal to its input (`cIn`, `dcIn`, `zIn`). `flagMask` bit 2 marks C, bit 1 marks DC and bit 0 marks Z as updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opSel | input | 5 | Operation code (see R2 to R9) |
| dBit | input | 1 | Destination select: 0 working register, 1 file register |
| wIn | input | 8 | Working register value |
| fIn | input | 8 | File-register operand |
| litIn | input | 8 | Literal operand |
| cIn | input | 1 | Current carry flag |
| dcIn | input | 1 | Current digit-carry flag |
| zIn | input | 1 | Current zero flag |
| outValid | output | 1 | Result beat valid |
| result | output | 8 | Result byte |
| wWe | output | 1 | Write result to the working register |
| fWe | output | 1 | Write result to the file register |
| cOut | output | 1 | New carry flag |
| dcOut | output | 1 | New digit-carry flag |
| zOut | output | 1 | New zero flag |
| flagMask | output | 3 | Flags updated: {C, DC, Z} |

## Verification
All results of an operation, including the write enables, flags and mask, fall due exactly one rising edge after the cycle in which the operation is driven. The driver changes inputs on falling edges and queues the expected beat at that moment. The monitor pops and compares on each following falling edge that shows `outValid`. This keeps samples half a cycle clear of the register update. An idle cycle is checked for `outValid` low on the next falling edge. Expected values come from a behavioural model that uses integer arithmetic with comparisons for borrows. It is exercised with directed corner operands and with random operands under both carry values and both destination settings.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,  OP_ADDC  = 5'd1,  OP_SUB   = 5'd2,  OP_SUBB  = 5'd3,
    OP_ADDK  = 5'd4,  OP_SUBK  = 5'd5,  OP_AND   = 5'd6,  OP_OR    = 5'd7,
    OP_XOR   = 5'd8,  OP_ANDK  = 5'd9,  OP_ORK   = 5'd10, OP_XORK  = 5'd11,
    OP_NOT   = 5'd12, OP_INC   = 5'd13, OP_DEC   = 5'd14, OP_PASS  = 5'd15,
    OP_STORE = 5'd16, OP_CLRF  = 5'd17, OP_CLRW  = 5'd18, OP_ASR   = 5'd19,
    OP_SHL   = 5'd20, OP_SHR   = 5'd21, OP_ROL   = 5'd22, OP_ROR   = 5'd23,
    OP_SWAP  = 5'd24, OP_LOADK = 5'd25
  } opcode_e;

  typedef enum logic [3:0] {
    U_ZERO, U_ARITH, U_AND, U_OR, U_XOR, U_NOT, U_INC, U_DEC,
    U_A, U_W, U_ASR, U_SHL, U_SHR, U_ROL, U_ROR, U_SWAP
  } unit_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_CARRY} cin_e;
  typedef enum logic [1:0] {DST_NONE, DST_BYBIT, DST_W, DST_F} dst_e;

  localparam int FLAG_C  = 2;
  localparam int FLAG_DC = 1;
  localparam int FLAG_Z  = 0;

  typedef struct packed {
    logic       srcLit;   // operand A is the literal instead of f
    logic       invW;     // operand B is ~W (subtraction)
    cin_e       cinSel;
    unit_e      unitSel;
    dst_e       dstSel;
    logic [2:0] updMask;  // {C, DC, Z}
  } ctrl_t;

endpackage

// File: rtl/byte_alu_ctrl.sv
module byte_alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic [4:0] opSel,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '{srcLit: 1'b0, invW: 1'b0, cinSel: CIN_ZERO, unitSel: U_ZERO,
             dstSel: DST_BYBIT, updMask: 3'b000};
    case (opSel)
      OP_ADD:   begin ctrl.unitSel = U_ARITH; ctrl.updMask = 3'b111; end
      OP_ADDC:  begin ctrl.unitSel = U_ARITH; ctrl.cinSel = CIN_CARRY; ctrl.updMask = 3'b111; end
      OP_SUB:   begin ctrl.unitSel = U_ARITH; ctrl.invW = 1'b1; ctrl.cinSel = CIN_ONE; ctrl.updMask = 3'b111; end
      OP_SUBB:  begin ctrl.unitSel = U_ARITH; ctrl.invW = 1'b1; ctrl.cinSel = CIN_CARRY; ctrl.updMask = 3'b111; end
      OP_ADDK:  begin ctrl.unitSel = U_ARITH; ctrl.srcLit = 1'b1; ctrl.dstSel = DST_W; ctrl.updMask = 3'b111; end
      OP_SUBK:  begin
        ctrl.unitSel = U_ARITH; ctrl.srcLit = 1'b1; ctrl.invW = 1'b1;
        ctrl.cinSel = CIN_ONE; ctrl.dstSel = DST_W; ctrl.updMask = 3'b111;
      end
      OP_AND:   begin ctrl.unitSel = U_AND; ctrl.updMask = 3'b001; end
      OP_OR:    begin ctrl.unitSel = U_OR;  ctrl.updMask = 3'b001; end
      OP_XOR:   begin ctrl.unitSel = U_XOR; ctrl.updMask = 3'b001; end
      OP_ANDK:  begin ctrl.unitSel = U_AND; ctrl.srcLit = 1'b1; ctrl.dstSel = DST_W; ctrl.updMask = 3'b001; end
      OP_ORK:   begin ctrl.unitSel = U_OR;  ctrl.srcLit = 1'b1; ctrl.dstSel = DST_W; ctrl.updMask = 3'b001; end
      OP_XORK:  begin ctrl.unitSel = U_XOR; ctrl.srcLit = 1'b1; ctrl.dstSel = DST_W; ctrl.updMask = 3'b001; end
      OP_NOT:   begin ctrl.unitSel = U_NOT; ctrl.updMask = 3'b001; end
      OP_INC:   begin ctrl.unitSel = U_INC; ctrl.updMask = 3'b001; end
      OP_DEC:   begin ctrl.unitSel = U_DEC; ctrl.updMask = 3'b001; end
      OP_PASS:  begin ctrl.unitSel = U_A;   ctrl.updMask = 3'b001; end
      OP_STORE: begin ctrl.unitSel = U_W;   ctrl.dstSel = DST_F; end
      OP_CLRF:  begin ctrl.unitSel = U_ZERO; ctrl.dstSel = DST_F; ctrl.updMask = 3'b001; end
      OP_CLRW:  begin ctrl.unitSel = U_ZERO; ctrl.dstSel = DST_W; ctrl.updMask = 3'b001; end
      OP_ASR:   begin ctrl.unitSel = U_ASR; ctrl.updMask = 3'b101; end
      OP_SHL:   begin ctrl.unitSel = U_SHL; ctrl.updMask = 3'b101; end
      OP_SHR:   begin ctrl.unitSel = U_SHR; ctrl.updMask = 3'b101; end
      OP_ROL:   begin ctrl.unitSel = U_ROL; ctrl.updMask = 3'b100; end
      OP_ROR:   begin ctrl.unitSel = U_ROR; ctrl.updMask = 3'b100; end
      OP_SWAP:  begin ctrl.unitSel = U_SWAP; end
      OP_LOADK: begin ctrl.unitSel = U_A; ctrl.srcLit = 1'b1; ctrl.dstSel = DST_W; end
      default:  begin ctrl.dstSel = DST_NONE; end
    endcase
  end

endmodule

// File: rtl/byte_alu_dp.sv
module byte_alu_dp
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  ctrl_t            ctrl,
  input  logic [WIDTH-1:0] wIn,
  input  logic [WIDTH-1:0] fIn,
  input  logic [WIDTH-1:0] litIn,
  input  logic             cIn,
  output logic [WIDTH-1:0] resNext,
  output logic             cNext,
  output logic             dcNext,
  output logic             zNext
);

  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] opA, opB;
  logic             carryIn;
  logic [WIDTH:0]   sum;
  logic [HALF:0]    halfSum;

  assign opA = ctrl.srcLit ? litIn : fIn;
  assign opB = ctrl.invW ? ~wIn : wIn;

  always_comb begin
    case (ctrl.cinSel)
      CIN_ONE:   carryIn = 1'b1;
      CIN_CARRY: carryIn = cIn;
      default:   carryIn = 1'b0;
    endcase
  end

  assign sum     = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
  assign halfSum = {1'b0, opA[HALF-1:0]} + {1'b0, opB[HALF-1:0]} + {{HALF{1'b0}}, carryIn};

  always_comb begin
    cNext  = 1'b0;
    dcNext = halfSum[HALF];
    case (ctrl.unitSel)
      U_ARITH: begin resNext = sum[WIDTH-1:0]; cNext = sum[WIDTH]; end
      U_AND:   resNext = opA & wIn;
      U_OR:    resNext = opA | wIn;
      U_XOR:   resNext = opA ^ wIn;
      U_NOT:   resNext = ~opA;
      U_INC:   resNext = opA + 1'b1;
      U_DEC:   resNext = opA - 1'b1;
      U_A:     resNext = opA;
      U_W:     resNext = wIn;
      U_ASR:   begin resNext = {opA[WIDTH-1], opA[WIDTH-1:1]}; cNext = opA[0]; end
      U_SHL:   begin resNext = {opA[WIDTH-2:0], 1'b0}; cNext = opA[WIDTH-1]; end
      U_SHR:   begin resNext = {1'b0, opA[WIDTH-1:1]}; cNext = opA[0]; end
      U_ROL:   begin resNext = {opA[WIDTH-2:0], cIn}; cNext = opA[WIDTH-1]; end
      U_ROR:   begin resNext = {cIn, opA[WIDTH-1:1]}; cNext = opA[0]; end
      U_SWAP:  resNext = {opA[HALF-1:0], opA[WIDTH-1:HALF]};
      default: resNext = '0;
    endcase
  end

  assign zNext = (resNext == '0);

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [4:0]       opSel,
  input  logic             dBit,
  input  logic [WIDTH-1:0] wIn,
  input  logic [WIDTH-1:0] fIn,
  input  logic [WIDTH-1:0] litIn,
  input  logic             cIn,
  input  logic             dcIn,
  input  logic             zIn,
  output logic             outValid,
  output logic [WIDTH-1:0] result,
  output logic             wWe,
  output logic             fWe,
  output logic             cOut,
  output logic             dcOut,
  output logic             zOut,
  output logic [2:0]       flagMask
);

  ctrl_t            ctrl;
  logic [WIDTH-1:0] resNext;
  logic             cNext, dcNext, zNext;
  logic             toW, toF;

  byte_alu_ctrl u_ctrl (.opSel(opSel), .ctrl(ctrl));

  byte_alu_dp #(.WIDTH(WIDTH)) u_dp (
    .ctrl(ctrl), .wIn(wIn), .fIn(fIn), .litIn(litIn), .cIn(cIn),
    .resNext(resNext), .cNext(cNext), .dcNext(dcNext), .zNext(zNext)
  );

  assign toW = (ctrl.dstSel == DST_W) || (ctrl.dstSel == DST_BYBIT && !dBit);
  assign toF = (ctrl.dstSel == DST_F) || (ctrl.dstSel == DST_BYBIT &&  dBit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      wWe      <= 1'b0;
      fWe      <= 1'b0;
      cOut     <= 1'b0;
      dcOut    <= 1'b0;
      zOut     <= 1'b0;
      flagMask <= 3'b000;
    end else begin
      outValid <= inValid;
      wWe      <= inValid && toW;
      fWe      <= inValid && toF;
      if (inValid) begin
        result   <= resNext;
        flagMask <= ctrl.updMask;
        cOut     <= ctrl.updMask[FLAG_C]  ? cNext  : cIn;
        dcOut    <= ctrl.updMask[FLAG_DC] ? dcNext : dcIn;
        zOut     <= ctrl.updMask[FLAG_Z]  ? zNext  : zIn;
      end
    end
  end

endmodule

// File: rtl/byte_alu_chk.sv
module byte_alu_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [4:0]       opSel,
  input logic [WIDTH-1:0] wIn,
  input logic [WIDTH-1:0] fIn,
  input logic             cIn,
  input logic             outValid,
  input logic [WIDTH-1:0] result,
  input logic             wWe,
  input logic             fWe,
  input logic             cOut,
  input logic             zOut,
  input logic [2:0]       flagMask
);

  localparam int HALF = WIDTH / 2;

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!wWe && !fWe));

  p_single_we_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({wWe, fWe}) <= 1);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && ($past(opSel) == 5'd17 || $past(opSel) == 5'd18)) |-> (result == '0 && zOut));

  p_rotl_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opSel) == 5'd22) |->
      (result[0] == $past(cIn) && cOut == $past(fIn[WIDTH-1]) && flagMask == 3'b100));

  p_swap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opSel) == 5'd24) |->
      (result == {$past(fIn[HALF-1:0]), $past(fIn[WIDTH-1:HALF])} && flagMask == 3'b000));

  p_store_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(opSel) == 5'd16) |-> (fWe && !wWe && result == $past(wIn)));

  p_zero_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagMask[0]) |-> (zOut == (result == '0)));

  p_carry_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !flagMask[2]) |-> (cOut == $past(cIn)));

endmodule

bind byte_alu byte_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .wIn(wIn),
  .fIn(fIn), .cIn(cIn), .outValid(outValid), .result(result), .wWe(wWe),
  .fWe(fWe), .cOut(cOut), .zOut(zOut), .flagMask(flagMask)
);

// File: tb/tb_byte_alu.sv
module tb_byte_alu;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [4:0] opSel = '0;
  logic       dBit = 1'b0;
  logic [7:0] wIn = '0, fIn = '0, litIn = '0;
  logic       cIn = 1'b0, dcIn = 1'b0, zIn = 1'b0;
  logic       outValid, wWe, fWe, cOut, dcOut, zOut;
  logic [7:0] result;
  logic [2:0] flagMask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [7:0] res;
    logic       we_w, we_f, c, dc, z;
    logic [2:0] mask;
    logic [4:0] op;
  } exp_t;

  exp_t expQ[$];

  always #5 clk = ~clk;

  byte_alu dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .dBit(dBit),
    .wIn(wIn), .fIn(fIn), .litIn(litIn), .cIn(cIn), .dcIn(dcIn), .zIn(zIn),
    .outValid(outValid), .result(result), .wWe(wWe), .fWe(fWe),
    .cOut(cOut), .dcOut(dcOut), .zOut(zOut), .flagMask(flagMask)
  );

  function automatic string reqOf(input logic [4:0] op);
    case (op)
      5'd0, 5'd1, 5'd4:                     return "R3";
      5'd2, 5'd3, 5'd5:                     return "R4";
      5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11,
      5'd12, 5'd13, 5'd14, 5'd15:           return "R5";
      5'd17, 5'd18:                         return "R6";
      5'd19, 5'd20, 5'd21:                  return "R7";
      5'd22, 5'd23:                         return "R8";
      5'd16, 5'd24, 5'd25:                  return "R9";
      default:                              return "R2";
    endcase
  endfunction

  function automatic exp_t model(input logic [4:0] op, input logic d,
                                 input int w, input int f, input int k,
                                 input logic c, input logic dc, input logic z);
    exp_t e;
    int s, bor, a;
    e.op = op; e.res = 8'h00; e.c = c; e.dc = dc; e.z = z; e.mask = 3'b000;
    e.we_w = !d; e.we_f = d;
    a = (op inside {5'd4, 5'd5, 5'd9, 5'd10, 5'd11, 5'd25}) ? k : f;
    if (op inside {5'd4, 5'd5, 5'd9, 5'd10, 5'd11, 5'd25, 5'd18}) begin e.we_w = 1; e.we_f = 0; end
    if (op inside {5'd16, 5'd17}) begin e.we_w = 0; e.we_f = 1; end
    case (op)
      5'd0, 5'd1, 5'd4: begin
        bor = (op == 5'd1) ? int'(c) : 0;
        s = a + w + bor;
        e.res = s[7:0]; e.c = (s > 255); e.dc = ((a % 16) + (w % 16) + bor) > 15;
        e.mask = 3'b111;
      end
      5'd2, 5'd3, 5'd5: begin
        bor = (op == 5'd3) ? int'(!c) : 0;
        s = a - w - bor;
        e.res = s[7:0]; e.c = (a >= w + bor); e.dc = ((a % 16) >= (w % 16) + bor);
        e.mask = 3'b111;
      end
      5'd6, 5'd9:   begin e.res = 8'(a & w); e.mask = 3'b001; end
      5'd7, 5'd10:  begin e.res = 8'(a | w); e.mask = 3'b001; end
      5'd8, 5'd11:  begin e.res = 8'(a ^ w); e.mask = 3'b001; end
      5'd12: begin e.res = 8'(255 - a); e.mask = 3'b001; end
      5'd13: begin e.res = 8'((a + 1) % 256); e.mask = 3'b001; end
      5'd14: begin e.res = 8'((a + 255) % 256); e.mask = 3'b001; end
      5'd15: begin e.res = 8'(a); e.mask = 3'b001; end
      5'd16: e.res = 8'(w);
      5'd17, 5'd18: begin e.res = 8'h00; e.mask = 3'b001; end
      5'd19: begin e.res = 8'((a / 2) + ((a >= 128) ? 128 : 0)); e.c = a[0]; e.mask = 3'b101; end
      5'd20: begin e.res = 8'((a * 2) % 256); e.c = (a >= 128); e.mask = 3'b101; end
      5'd21: begin e.res = 8'(a / 2); e.c = a[0]; e.mask = 3'b101; end
      5'd22: begin e.res = 8'((a * 2) % 256 + int'(c)); e.c = (a >= 128); e.mask = 3'b100; end
      5'd23: begin e.res = 8'(a / 2 + (c ? 128 : 0)); e.c = a[0]; e.mask = 3'b100; end
      5'd24: e.res = 8'((a % 16) * 16 + a / 16);
      5'd25: e.res = 8'(a);
      default: begin e.we_w = 0; e.we_f = 0; end
    endcase
    if (e.mask[0]) e.z = (e.res == 8'h00);
    return e;
  endfunction

  task automatic send(input logic [4:0] op, input logic d, input logic [7:0] w,
                      input logic [7:0] f, input logic [7:0] k,
                      input logic c, input logic dc, input logic z);
    @(negedge clk);
    inValid = 1'b1; opSel = op; dBit = d; wIn = w; fIn = f; litIn = k;
    cIn = c; dcIn = dc; zIn = z;
    expQ.push_back(model(op, d, int'(w), int'(f), int'(k), c, dc, z));
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: outputs update at posedge, compared on the following falling edge
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R1: unexpected output beat, result=%h expected no beat", result);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (result !== e.res || wWe !== e.we_w || fWe !== e.we_f || cOut !== e.c ||
            dcOut !== e.dc || zOut !== e.z || flagMask !== e.mask) begin
          fails++;
          $display("FAIL %s/R10 op=%0d: got res=%h wWe=%b fWe=%b c=%b dc=%b z=%b mask=%b, expected res=%h wWe=%b fWe=%b c=%b dc=%b z=%b mask=%b",
                   reqOf(e.op), e.op, result, wWe, fWe, cOut, dcOut, zOut, flagMask,
                   e.res, e.we_w, e.we_f, e.c, e.dc, e.z, e.mask);
        end
      end
    end
  end

  task automatic checkIdle();
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || wWe !== 1'b0 || fWe !== 1'b0) begin
      fails++;
      $display("FAIL R1: idle beat outValid=%b wWe=%b fWe=%b expected 0 0 0", outValid, wWe, fWe);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (outValid !== 0 || result !== 0 || wWe !== 0 || fWe !== 0 ||
        cOut !== 0 || dcOut !== 0 || zOut !== 0 || flagMask !== 0) begin
      fails++;
      $display("FAIL R1: reset state outValid=%b result=%h flags=%b%b%b mask=%b expected all zero",
               outValid, result, cOut, dcOut, zOut, flagMask);
    end
    @(negedge clk); rstN = 1'b1;

    // R3 corners: carry out of bit 7 and bit 3, zero result, carry-in chaining
    send(5'd0, 0, 8'hFF, 8'h01, 8'h00, 0, 0, 0);
    send(5'd0, 1, 8'h08, 8'h08, 8'h00, 1, 0, 1);
    send(5'd1, 0, 8'hFF, 8'h00, 8'h00, 1, 0, 0);
    send(5'd4, 0, 8'h0F, 8'h00, 8'h01, 0, 0, 0);
    // R4 corners: equal operands, borrow, borrow chaining
    send(5'd2, 0, 8'h10, 8'h10, 8'h00, 0, 0, 0);
    send(5'd2, 1, 8'h01, 8'h00, 8'h00, 1, 1, 1);
    send(5'd3, 0, 8'h00, 8'h00, 8'h00, 0, 0, 0);
    send(5'd3, 0, 8'h00, 8'h00, 8'h00, 1, 0, 0);
    send(5'd5, 0, 8'h01, 8'h00, 8'h10, 0, 0, 0);
    // R5, R6, R7, R8, R9 corners with opposite incoming flags
    send(5'd13, 1, 8'h00, 8'hFF, 8'h00, 1, 1, 0);
    send(5'd14, 0, 8'h00, 8'h00, 8'h00, 0, 1, 1);
    send(5'd17, 0, 8'h55, 8'hAA, 8'h00, 1, 1, 0);
    send(5'd18, 1, 8'h55, 8'hAA, 8'h00, 0, 0, 0);
    send(5'd19, 0, 8'h00, 8'h81, 8'h00, 0, 0, 0);
    send(5'd20, 1, 8'h00, 8'h80, 8'h00, 0, 1, 0);
    send(5'd21, 0, 8'h00, 8'h01, 8'h00, 0, 0, 0);
    send(5'd22, 0, 8'h00, 8'h80, 8'h00, 0, 1, 1);
    send(5'd23, 1, 8'h00, 8'h01, 8'h00, 1, 0, 0);
    send(5'd24, 0, 8'h00, 8'h00, 8'h00, 1, 1, 0);
    send(5'd16, 0, 8'hC3, 8'h00, 8'h00, 1, 0, 1);
    send(5'd25, 1, 8'h00, 8'h00, 8'h00, 0, 1, 1);
    send(5'd30, 0, 8'h12, 8'h34, 8'h56, 1, 0, 1); // R2 undefined code
    idle();
    checkIdle();
    checkIdle();

    // Random sweep: every defined and undefined code, both carries, both destinations
    for (int op = 0; op < 32; op++) begin
      for (int n = 0; n < 24; n++) begin
        send(5'(op), 1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
             1'(n % 2), 1'($urandom), 1'($urandom));
      end
      if (op % 8 == 7) begin idle(); checkIdle(); end
    end
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1: %0d expected beats never produced, expected 0", expQ.size());
    end
    finishRun();
  end

endmodule